// File: doc/BRIEF.md
# Embedded Controller Host Port

This block is the host-facing side of a system embedded controller. A host CPU reaches it through two byte-wide I/O locations on a simple strobe bus. One location is a data port and the other is a command/status port. The host sends a command byte, then an address byte if the command needs one, then a data byte if the command needs one. Between steps it polls the status byte to see whether the controller has taken its last byte and whether a result is waiting.

Inside the block sit a small byte-addressed register space, a phase tracker for the command/address/data sequence, a data register that holds results for the host, and four status flags. A one-cycle interrupt pulse marks each new result.

The sequences are:
- Read: command, address, then the host reads the data port.
- Write: command, address, data.
- Burst enable: the block answers with an acknowledge byte.
- Burst disable.
- Query: the block answers "no event pending".

Top module: `ec_host_if`

## Requirements
- R1: After reset the status byte and the data register both read 0x00, and no interrupt pulse has occurred.
- R2: With default parameters the data port is bus address 0x62 and the command/status port is 0x66. A read of any other address returns 0x00, and a write to any other address has no effect.
- R3: The status byte reports output-full at bit 0, input-busy at bit 1, command-flag at bit 3 and burst at bit 4. All other bits read 0.
- R4: An accepted write to either port sets input-busy, and input-busy is clear again one cycle later. A write to the command port also sets command-flag. Any write that arrives while input-busy is set is dropped.
- R5: An accepted data-port write clears command-flag.
- R6: After command 0x80 and an address byte below 0x80, the data register holds the stored byte and output-full is set. If the address byte is 0x80 or above, the data register holds 0x00 and output-full is set.
- R7: After command 0x81, an address byte and a data byte, the byte is stored at that address. If the address is 0x80 or above, the register space is left unchanged.
- R8: Command 0x82 sets burst, loads 0x90 into the data register and sets output-full. Command 0x83 clears burst.
- R9: Command 0x84 loads 0x00 into the data register and sets output-full.
- R10: A command byte other than 0x80 to 0x84 changes nothing except input-busy and command-flag, and it cancels any sequence in progress.
- R11: A host read of the data port clears output-full. A read of the status byte does not.
- R12: The interrupt output is high for exactly one cycle each time output-full goes from 0 to 1.
- R13: A data-port write that arrives with no read or write sequence waiting for it is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Host I/O address |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid in the cycle of bus_rd |
| irq | output | 1 | One-cycle result interrupt |

## Verification
The bound checker watches four rules on every cycle:
- input-busy never stays high for two cycles;
- a write dropped while input-busy is set leaves command-flag alone;
- output-full only falls after a host read of the data port;
- every interrupt cycle lines up with a rising output-full, and no store write targets an address outside the space.

Only the bench's scenarios can show the values that go through the register space and the effect of each command code:
- a full write sweep and read-back of all 128 locations;
- a sweep of writes above the space;
- a sweep of every undefined command code;
- burst, query, dropped back-to-back writes and stray data bytes.

// File: rtl/ec_host_pkg.sv
package ec_host_pkg;

   typedef enum logic [1:0] {
      PH_IDLE    = 2'd0,
      PH_RD_ADDR = 2'd1,
      PH_WR_ADDR = 2'd2,
      PH_WR_DATA = 2'd3
   } phase_t;

   localparam logic [7:0] OP_READ      = 8'h80;
   localparam logic [7:0] OP_WRITE     = 8'h81;
   localparam logic [7:0] OP_BURST_ON  = 8'h82;
   localparam logic [7:0] OP_BURST_OFF = 8'h83;
   localparam logic [7:0] OP_QUERY     = 8'h84;

   localparam int ST_OUT_FULL = 0;
   localparam int ST_IN_BUSY  = 1;
   localparam int ST_CMD      = 3;
   localparam int ST_BURST    = 4;

endpackage

// File: rtl/ec_host_capture.sv
module ec_host_capture #(
   parameter int                ADDR_W    = 8,
   parameter logic [ADDR_W-1:0] DATA_PORT = 'h62,
   parameter logic [ADDR_W-1:0] CMD_PORT  = 'h66
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic              in_busy,
   output logic              hb_is_cmd,
   output logic [7:0]        hb_byte,
   output logic              cmd_flag
);

   logic hit_cmd, hit_data, accept;

   assign hit_cmd  = bus_wr && (bus_addr == CMD_PORT);
   assign hit_data = bus_wr && (bus_addr == DATA_PORT);
   assign accept   = (hit_cmd || hit_data) && !in_busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_busy   <= 1'b0;
         hb_is_cmd <= 1'b0;
         hb_byte   <= 8'h00;
         cmd_flag  <= 1'b0;
      end else begin
         in_busy <= accept;
         if (accept) begin
            hb_is_cmd <= hit_cmd;
            hb_byte   <= bus_wdata;
            cmd_flag  <= hit_cmd;
         end
      end
   end

endmodule

// File: rtl/ec_host_store.sv
module ec_host_store #(
   parameter int DEPTH          = 128,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int IDX_W         = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       we,
   input  logic [7:0] waddr,
   input  logic [7:0] wdata,
   input  logic [7:0] raddr,
   output logic [7:0] rdata
);

   localparam logic [8:0] LIMIT = 9'(DEPTH);

   logic [7:0] mem [DEPTH];
   logic       w_ok, r_ok;

   assign w_ok  = we && ({1'b0, waddr} < LIMIT);
   assign r_ok  = {1'b0, raddr} < LIMIT;
   assign rdata = r_ok ? mem[raddr[IDX_W-1:0]] : 8'h00;

   generate
      if (CLEAR_ON_RESET) begin : g_clr
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
            end else if (w_ok) begin
               mem[waddr[IDX_W-1:0]] <= wdata;
            end
         end
      end else begin : g_plain
         always_ff @(posedge clk) begin
            if (w_ok) mem[waddr[IDX_W-1:0]] <= wdata;
         end
      end
   endgenerate

endmodule

// File: rtl/ec_host_engine.sv
module ec_host_engine
   import ec_host_pkg::*;
#(
   parameter int         DEPTH     = 128,
   parameter logic [7:0] BURST_ACK = 8'h90,
   parameter logic [7:0] NO_EVENT  = 8'h00
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hb_valid,
   input  logic       hb_is_cmd,
   input  logic [7:0] hb_byte,
   input  logic       host_data_rd,
   input  logic [7:0] store_rdata,
   output logic       store_we,
   output logic [7:0] store_waddr,
   output logic [7:0] store_raddr,
   output logic       out_full,
   output logic       burst,
   output logic [7:0] data_reg,
   output logic       irq
);

   localparam logic [8:0] LIMIT = 9'(DEPTH);

   phase_t     phase_q, phase_d;
   logic [7:0] addr_q;
   logic       res_set;
   logic [7:0] res_val;
   logic       burst_d;

   assign store_raddr = hb_byte;
   assign store_waddr = addr_q;
   assign store_we    = hb_valid && !hb_is_cmd && (phase_q == PH_WR_DATA)
                        && ({1'b0, addr_q} < LIMIT);

   always_comb begin
      phase_d = phase_q;
      res_set = 1'b0;
      res_val = data_reg;
      burst_d = burst;
      if (hb_valid) begin
         if (hb_is_cmd) begin
            phase_d = PH_IDLE;
            unique case (hb_byte)
               OP_READ:      phase_d = PH_RD_ADDR;
               OP_WRITE:     phase_d = PH_WR_ADDR;
               OP_BURST_ON:  begin burst_d = 1'b1; res_set = 1'b1; res_val = BURST_ACK; end
               OP_BURST_OFF: burst_d = 1'b0;
               OP_QUERY:     begin res_set = 1'b1; res_val = NO_EVENT; end
               default:      ;
            endcase
         end else begin
            unique case (phase_q)
               PH_RD_ADDR: begin
                  res_set = 1'b1;
                  res_val = store_rdata;
                  phase_d = PH_IDLE;
               end
               PH_WR_ADDR: phase_d = PH_WR_DATA;
               PH_WR_DATA: phase_d = PH_IDLE;
               default:    ;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q  <= PH_IDLE;
         addr_q   <= 8'h00;
         out_full <= 1'b0;
         burst    <= 1'b0;
         data_reg <= 8'h00;
         irq      <= 1'b0;
      end else begin
         phase_q <= phase_d;
         burst   <= burst_d;
         irq     <= res_set && !out_full;
         if (hb_valid && !hb_is_cmd && phase_q == PH_WR_ADDR) addr_q <= hb_byte;
         if (res_set) begin
            out_full <= 1'b1;
            data_reg <= res_val;
         end else if (host_data_rd) begin
            out_full <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/ec_host_if.sv
module ec_host_if
   import ec_host_pkg::*;
#(
   parameter int                ADDR_W         = 8,
   parameter logic [ADDR_W-1:0] DATA_PORT      = 'h62,
   parameter logic [ADDR_W-1:0] CMD_PORT       = 'h66,
   parameter int                SPACE_DEPTH    = 128,
   parameter logic [7:0]        BURST_ACK      = 8'h90,
   parameter bit                CLEAR_ON_RESET = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   output logic              irq
);

   if (DATA_PORT == CMD_PORT) begin : g_bad_ports
      $error("ec_host_if: data and command ports must differ");
   end
   if (SPACE_DEPTH < 2 || SPACE_DEPTH > 256) begin : g_bad_depth
      $error("ec_host_if: SPACE_DEPTH must be within 2..256");
   end

   logic       in_busy, hb_is_cmd, cmd_flag;
   logic [7:0] hb_byte;
   logic       store_we;
   logic [7:0] store_waddr, store_raddr, store_rdata;
   logic       out_full, burst;
   logic [7:0] data_reg, status;
   logic       host_data_rd;

   assign host_data_rd = bus_rd && (bus_addr == DATA_PORT);

   ec_host_capture #(
      .ADDR_W(ADDR_W), .DATA_PORT(DATA_PORT), .CMD_PORT(CMD_PORT)
   ) cap_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .in_busy(in_busy), .hb_is_cmd(hb_is_cmd),
      .hb_byte(hb_byte), .cmd_flag(cmd_flag)
   );

   ec_host_engine #(
      .DEPTH(SPACE_DEPTH), .BURST_ACK(BURST_ACK), .NO_EVENT(8'h00)
   ) eng_i (
      .clk(clk), .rst_n(rst_n), .hb_valid(in_busy), .hb_is_cmd(hb_is_cmd),
      .hb_byte(hb_byte), .host_data_rd(host_data_rd), .store_rdata(store_rdata),
      .store_we(store_we), .store_waddr(store_waddr), .store_raddr(store_raddr),
      .out_full(out_full), .burst(burst), .data_reg(data_reg), .irq(irq)
   );

   ec_host_store #(
      .DEPTH(SPACE_DEPTH), .CLEAR_ON_RESET(CLEAR_ON_RESET)
   ) mem_i (
      .clk(clk), .rst_n(rst_n), .we(store_we), .waddr(store_waddr),
      .wdata(hb_byte), .raddr(store_raddr), .rdata(store_rdata)
   );

   always_comb begin
      status = 8'h00;
      status[ST_OUT_FULL] = out_full;
      status[ST_IN_BUSY]  = in_busy;
      status[ST_CMD]      = cmd_flag;
      status[ST_BURST]    = burst;
   end

   always_comb begin
      bus_rdata = 8'h00;
      if (bus_rd) begin
         if (bus_addr == DATA_PORT)     bus_rdata = data_reg;
         else if (bus_addr == CMD_PORT) bus_rdata = status;
      end
   end

endmodule

// File: rtl/ec_host_if_chk.sv
module ec_host_if_chk #(
   parameter int                ADDR_W      = 8,
   parameter logic [ADDR_W-1:0] DATA_PORT   = 'h62,
   parameter int                SPACE_DEPTH = 128
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic              in_busy,
   input logic              cmd_flag,
   input logic              out_full,
   input logic              irq,
   input logic              store_we,
   input logic [7:0]        store_waddr
);

   localparam logic [8:0] LIMIT = 9'(SPACE_DEPTH);

   assert_busy_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      in_busy |=> !in_busy);

   assert_drop_keeps_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_busy && bus_wr) |=> (cmd_flag == $past(cmd_flag)));

   assert_full_falls_on_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(out_full) |-> $past(bus_rd && bus_addr == DATA_PORT));

   assert_irq_on_rise_R12: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (out_full && !$past(out_full)));

   assert_store_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      store_we |-> ({1'b0, store_waddr} < LIMIT));

endmodule

bind ec_host_if ec_host_if_chk #(
   .ADDR_W(ADDR_W), .DATA_PORT(DATA_PORT), .SPACE_DEPTH(SPACE_DEPTH)
) chk_i (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
   .bus_rd(bus_rd), .in_busy(in_busy), .cmd_flag(cmd_flag),
   .out_full(out_full), .irq(irq), .store_we(store_we),
   .store_waddr(store_waddr)
);

// File: tb/ec_host_if_tb_top.sv
`timescale 1ns/1ps
module ec_host_if_tb_top;

   localparam logic [7:0] DP = 8'h62;
   localparam logic [7:0] CP = 8'h66;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] bus_addr = 8'h00;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       irq;

   int checks = 0;
   int errors = 0;
   int irq_cnt = 0;
   int exp_irq = 0;
   logic [7:0] model [128];
   logic [7:0] v;

   always #4 clk = ~clk;

   ec_host_if dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   always @(negedge clk) if (rst_n && irq) irq_cnt++;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // write, then one idle cycle so the block has consumed the byte
   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_wr = 1'b0;
      @(negedge clk);
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk); bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk); bus_rd = 1'b0;
   endtask

   function automatic logic [7:0] pat(input int a);
      return 8'((a * 7 + 3) ^ 8'h5A);
   endfunction

   initial begin
      for (int i = 0; i < 128; i++) model[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      rd(CP, v); chk("R1 status", v, 8'h00);
      rd(DP, v); chk("R1 data", v, 8'h00);
      chk("R1 irq", irq_cnt, 0);

      rd(8'h10, v); chk("R2 stray read", v, 8'h00);
      wr(8'h60, 8'h82);
      rd(CP, v); chk("R2 stray write", v, 8'h00);

      // peek status right after capture: busy + cmd
      @(negedge clk); bus_wr = 1'b1; bus_addr = CP; bus_wdata = 8'h81;
      @(negedge clk); bus_wr = 1'b0; bus_rd = 1'b1;
      #1 chk("R4 R3 busy+cmd", bus_rdata, 8'h0A);
      @(negedge clk); #1 chk("R4 busy cleared", bus_rdata, 8'h08);
      bus_rd = 1'b0;
      wr(DP, 8'h00);
      rd(CP, v); chk("R5 cmd cleared", v, 8'h00);
      wr(DP, pat(0)); model[0] = pat(0);

      for (int a = 1; a < 128; a++) begin
         wr(CP, 8'h81); wr(DP, 8'(a)); wr(DP, pat(a)); model[a] = pat(a);
      end
      for (int a = 0; a < 128; a++) begin
         wr(CP, 8'h80); wr(DP, 8'(a)); exp_irq++;
         rd(CP, v); chk("R6 R3 out full", v, 8'h01);
         rd(DP, v); chk("R6 readback", v, model[a]);
         rd(CP, v); chk("R11 read clears", v, 8'h00);
      end
      chk("R12 irq count", irq_cnt, exp_irq);

      for (int a = 128; a < 256; a++) begin
         wr(CP, 8'h81); wr(DP, 8'(a)); wr(DP, 8'hEE);
      end
      for (int a = 0; a < 128; a += 9) begin
         wr(CP, 8'h80); wr(DP, 8'(a)); exp_irq++;
         rd(DP, v); chk("R7 out of range untouched", v, model[a]);
      end
      wr(CP, 8'h80); wr(DP, 8'hC3); exp_irq++;
      rd(DP, v); chk("R6 out of range read", v, 8'h00);

      wr(CP, 8'h82); exp_irq++;
      rd(CP, v); chk("R8 burst status", v, 8'h19);
      rd(DP, v); chk("R8 burst ack", v, 8'h90);
      rd(CP, v); chk("R8 R11 after read", v, 8'h18);
      wr(CP, 8'h83);
      rd(CP, v); chk("R8 burst off", v, 8'h08);

      wr(CP, 8'h84); exp_irq++;
      rd(CP, v); chk("R9 query status", v, 8'h09);
      rd(CP, v); chk("R11 status read keeps full", v, 8'h09);
      rd(DP, v); chk("R9 query data", v, 8'h00);

      for (int c = 0; c < 256; c++) begin
         if (c >= 8'h80 && c <= 8'h84) continue;
         wr(CP, 8'(c));
         rd(CP, v); chk("R10 unknown code", v, 8'h08);
      end
      wr(CP, 8'h81); wr(CP, 8'h99); wr(DP, 8'h05); wr(DP, 8'h77);
      wr(CP, 8'h80); wr(DP, 8'h05); exp_irq++;
      rd(DP, v); chk("R10 sequence cancelled", v, model[5]);

      wr(DP, 8'h03); wr(DP, 8'h55);
      wr(CP, 8'h80); wr(DP, 8'h03); exp_irq++;
      rd(DP, v); chk("R13 stray data", v, model[3]);

      // back-to-back: second write lands while busy and is dropped
      @(negedge clk); bus_wr = 1'b1; bus_addr = CP; bus_wdata = 8'h81;
      @(negedge clk); bus_addr = DP; bus_wdata = 8'h10;
      @(negedge clk); bus_wr = 1'b0;
      rd(CP, v); chk("R4 dropped keeps cmd", v, 8'h08);
      wr(DP, 8'h20); wr(DP, 8'hAB); model[32] = 8'hAB;
      wr(CP, 8'h80); wr(DP, 8'h20); exp_irq++;
      rd(DP, v); chk("R4 write after drop", v, 8'hAB);
      wr(CP, 8'h80); wr(DP, 8'h10); exp_irq++;
      rd(DP, v); chk("R4 dropped byte unused", v, model[16]);

      @(negedge clk); @(negedge clk);
      chk("R12 irq total", irq_cnt, exp_irq);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule